// File: doc/BRIEF.md
# Keyed-Unlock Watchdog Timer

This peripheral is a watchdog timer that sits on a plain word-addressed register bus with an address, a write strobe, write data and combinational read data. Four settings can change the watchdog's behaviour: restart, reload value, enable, and prescale. Each of these settings has its own guard register. Software must write that guard's key words in the right order before a write to the setting takes effect. Every such write closes the guard again.

A prescaler divides the bus clock. Each prescaler tick moves a 16-bit down-counter one step. Once the watchdog is enabled, the reset output pulses high when the counter runs out, and the counter then reloads by itself. Software keeps the system alive by restarting the counter through the guarded restart setting before the timeout elapses. The timeout in clocks is the reload value times the prescale value.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset the watchdog is disabled, wdt_rst_o is low, every guard reads 0, and the prescale and reload values are both 0xFFFF.
- R2: Word address 0 is the restart guard and 1 is restart. Address 2 is the reload guard and 3 is reload. Address 4 is the enable guard and 5 is enable. Address 6 is the prescale guard and 7 is prescale. A read of a guard returns its progress in bits [1:0] with zeros above. A read of addresses 1, 3, 5 and 7 returns 0.
- R3: The two-key guards compare the low 16 bits of the write data. They read 1 after their first key and 3 after their second key. The restart keys are 0x5555 then 0xAAAA. The reload keys are 0x6666 then 0xBBBB. The prescale keys are 0x5A5A then 0xA5A5.
- R4: The enable guard needs three keys in order: 0x7777 gives progress 1, 0xCCCC gives 2, and 0xDDDD gives 3. Progress 3 is reachable only from progress 2.
- R5: A guard write that is not the next expected key sets that guard to 0, unless it equals the guard's first key, which sets it to 1.
- R6: A write to a setting whose guard does not read 3 is ignored. Any write to a setting returns its guard to 0.
- R7: Bit 0 of an accepted enable write turns the watchdog on (1) or off (0). While the watchdog is off, the prescaler and counter hold and wdt_rst_o stays low.
- R8: An accepted restart write, with any data, reloads the counter from the reload value and clears the prescaler.
- R9: An accepted reload write stores the value clamped to the range 1 to 0xFFFF. The stored value is used at the next reload. An accepted prescale write stores bits [15:0], and 0 is treated as 1.
- R10: While the watchdog is enabled, with reload C and prescale P, wdt_rst_o is high for one cycle, C*P cycles after the restart edge. It then repeats every C*P cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus and watchdog clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 3 | Word address |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| wdt_rst_o | output | 1 | Watchdog reset pulse |

## Verification
A guard with a wrong progress value shows up on the next read of its address. It also shows up one write later, because a setting write is either dropped or accepted at the wrong time. A fault in the prescaler or the counter moves the wdt_rst_o pulse by whole ticks. The bench therefore measures the exact distance from the restart edge to each pulse, and a per-cycle reference model flags any drift in the very cycle the pulse differs. A wrongly accepted enable or reload write is caught by quiet windows, or by periods that do not match the value programmed under an open guard.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned NUM_LOCKS = 4;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned ADDR_W    = 3;
  localparam int unsigned CNT_W     = 16;
  localparam int unsigned KEY_W     = 16;

  localparam int unsigned LK_KICK = 0;
  localparam int unsigned LK_CHG  = 1;
  localparam int unsigned LK_DIS  = 2;
  localparam int unsigned LK_PSC  = 3;

  localparam logic [1:0] ST_IDLE = 2'd0;
  localparam logic [1:0] ST_ONE  = 2'd1;
  localparam logic [1:0] ST_TWO  = 2'd2;
  localparam logic [1:0] ST_OPEN = 2'd3;

  function automatic int unsigned lock_nkeys(int unsigned lk);
    return (lk == LK_DIS) ? 3 : 2;
  endfunction

  function automatic logic [KEY_W-1:0] lock_key(int unsigned lk, int unsigned step);
    logic [KEY_W-1:0] k;
    k = '0;
    case (lk)
      LK_KICK: k = (step == 0) ? 16'h5555 : 16'hAAAA;
      LK_CHG:  k = (step == 0) ? 16'h6666 : 16'hBBBB;
      LK_DIS:  k = (step == 0) ? 16'h7777 : (step == 1) ? 16'hCCCC : 16'hDDDD;
      default: k = (step == 0) ? 16'h5A5A : 16'hA5A5;
    endcase
    return k;
  endfunction
endpackage

// File: rtl/wdt_lock.sv
module wdt_lock
  import wdt_pkg::*;
#(
  parameter int unsigned       NKEYS = 2,
  parameter logic [KEY_W-1:0]  KEY0  = '0,
  parameter logic [KEY_W-1:0]  KEY1  = '0,
  parameter logic [KEY_W-1:0]  KEY2  = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lock_we_i,
  input  logic             prot_we_i,
  input  logic [KEY_W-1:0] key_i,
  output logic [1:0]       state_o
);
  localparam logic [1:0] AFTER_SECOND = (NKEYS == 3) ? ST_TWO : ST_OPEN;

  logic [1:0]       state_q, state_d, adv;
  logic [KEY_W-1:0] exp_key;
  logic             has_step;

  always_comb begin
    exp_key  = KEY0;
    adv      = ST_ONE;
    has_step = 1'b1;
    unique case (state_q)
      ST_IDLE: ;
      ST_ONE: begin
        exp_key = KEY1;
        adv     = AFTER_SECOND;
      end
      ST_TWO: begin
        exp_key = KEY2;
        adv     = ST_OPEN;
      end
      default: has_step = 1'b0;
    endcase
  end

  always_comb begin
    state_d = state_q;
    if (prot_we_i) begin
      state_d = ST_IDLE;
    end else if (lock_we_i) begin
      if (has_step && key_i == exp_key) state_d = adv;
      else if (key_i == KEY0)           state_d = ST_ONE;
      else                              state_d = ST_IDLE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int unsigned PSC_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             restart_i,
  input  logic [PSC_W-1:0] psc_i,
  output logic             tick_o
);
  logic [PSC_W-1:0] pre_q;

  // psc_i is never 0, so psc_i - 1 does not wrap
  assign tick_o = en_i && (pre_q >= psc_i - PSC_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        pre_q <= '0;
    else if (restart_i) pre_q <= '0;
    else if (en_i)      pre_q <= tick_o ? '0 : pre_q + PSC_W'(1);
  end
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             reload_i,
  input  logic [CNT_W-1:0] chg_i,
  output logic             expire_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  assign expire_o = tick_i && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '1;
    else if (reload_i) cnt_q <= chg_i;
    else if (tick_i)   cnt_q <= expire_o ? chg_i : cnt_q - CNT_W'(1);
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
  import wdt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              wdt_rst_o
);
  localparam int unsigned NUM_REGS = 2 * NUM_LOCKS;
  localparam logic [DATA_W-1:0] CNT_MAX = {{(DATA_W-CNT_W){1'b0}}, {CNT_W{1'b1}}};

  logic [NUM_REGS-1:0]        hit;
  logic [NUM_LOCKS-1:0]       lock_we, prot_we, prot_ok;
  logic [NUM_LOCKS-1:0][1:0]  lock_st;
  logic                       en_q, rst_q, tick, expire;
  logic [CNT_W-1:0]           chg_q, psc_q, cnt_q, chg_new, psc_new;

  assign hit = {NUM_REGS{we_i}} & (NUM_REGS'(1) << addr_i);

  for (genvar k = 0; k < NUM_LOCKS; k++) begin : g_lock
    assign lock_we[k] = hit[2*k];
    assign prot_we[k] = hit[2*k+1];
    assign prot_ok[k] = prot_we[k] && (lock_st[k] == ST_OPEN);

    wdt_lock #(
      .NKEYS (lock_nkeys(k)),
      .KEY0  (lock_key(k, 0)),
      .KEY1  (lock_key(k, 1)),
      .KEY2  (lock_key(k, 2))
    ) u_lock (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .lock_we_i (lock_we[k]),
      .prot_we_i (prot_we[k]),
      .key_i     (wdata_i[KEY_W-1:0]),
      .state_o   (lock_st[k])
    );
  end

  // clamp reload to [1, max]; prescale 0 acts as 1
  always_comb begin
    if (wdata_i == '0)         chg_new = CNT_W'(1);
    else if (wdata_i > CNT_MAX) chg_new = '1;
    else                        chg_new = wdata_i[CNT_W-1:0];
    psc_new = (wdata_i[CNT_W-1:0] == '0) ? CNT_W'(1) : wdata_i[CNT_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      chg_q <= '1;
      psc_q <= '1;
      rst_q <= 1'b0;
    end else begin
      if (prot_ok[LK_DIS]) en_q  <= wdata_i[0];
      if (prot_ok[LK_CHG]) chg_q <= chg_new;
      if (prot_ok[LK_PSC]) psc_q <= psc_new;
      rst_q <= expire;
    end
  end

  wdt_prescaler #(.PSC_W(CNT_W)) u_psc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_q),
    .restart_i (prot_ok[LK_KICK]),
    .psc_i     (psc_q),
    .tick_o    (tick)
  );

  wdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick),
    .reload_i (prot_ok[LK_KICK]),
    .chg_i    (chg_q),
    .expire_o (expire),
    .cnt_o    (cnt_q)
  );

  assign rdata_o   = addr_i[0] ? '0 : {{(DATA_W-2){1'b0}}, lock_st[addr_i[ADDR_W-1:1]]};
  assign wdt_rst_o = rst_q;
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker
  import wdt_pkg::*;
(
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      we_i,
  input logic [ADDR_W-1:0]         addr_i,
  input logic                      en_q,
  input logic [NUM_LOCKS-1:0][1:0] lock_st,
  input logic [CNT_W-1:0]          cnt_q,
  input logic [CNT_W-1:0]          chg_q,
  input logic [CNT_W-1:0]          psc_q,
  input logic                      wdt_rst_o
);
  AST_OFF_NO_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |=> !wdt_rst_o); // R7

  AST_ENABLE_GUARDED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(en_q) |-> $past(we_i && addr_i == 3'd5 && lock_st[LK_DIS] == ST_OPEN)); // R6

  AST_PROT_CLEARS_GUARD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == 3'd5) |=> lock_st[LK_DIS] == ST_IDLE); // R6

  AST_DIS_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_st[LK_DIS] == ST_OPEN && $past(lock_st[LK_DIS]) != ST_OPEN)
      |-> $past(lock_st[LK_DIS]) == ST_TWO); // R4

  AST_CNT_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q != '0); // R10

  AST_CFG_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chg_q != '0 && psc_q != '0); // R9
endmodule

bind keyed_watchdog wdt_checker u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .we_i      (we_i),
  .addr_i    (addr_i),
  .en_q      (en_q),
  .lock_st   (lock_st),
  .cnt_q     (cnt_q),
  .chg_q     (chg_q),
  .psc_q     (psc_q),
  .wdt_rst_o (wdt_rst_o)
);

// File: tb/sim_keyed_watchdog.sv
module sim_keyed_watchdog;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  addr_i = '0;
  logic        we_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        wdt_rst_o;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 0;

  keyed_watchdog u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .we_i(we_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .wdt_rst_o(wdt_rst_o)
  );

  always #10 clk_i = ~clk_i;

  int keys [4][3] = '{'{'h5555, 'hAAAA, 0}, '{'h6666, 'hBBBB, 0},
                      '{'h7777, 'hCCCC, 'hDDDD}, '{'h5A5A, 'hA5A5, 0}};

  // behavioural reference
  int m_lock [4];
  int m_en, m_pre, m_cnt, m_chg, m_psc, m_rst;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      foreach (m_lock[i]) m_lock[i] = 0;
      m_en = 0; m_pre = 0; m_cnt = 'hFFFF; m_chg = 'hFFFF; m_psc = 'hFFFF; m_rst = 0;
    end else begin
      int k, nk, step, key, d;
      bit tk, ex, kick;
      tk = (m_en != 0) && (m_pre >= m_psc - 1);
      ex = tk && (m_cnt == 1);
      kick = 0;
      k = int'(addr_i) / 2;
      d = int'(wdata_i);
      if (we_i && addr_i[0] && m_lock[k] == 3 && k == 0) kick = 1;
      if (kick) begin m_pre = 0; m_cnt = m_chg; end
      else begin
        if (m_en != 0) m_pre = tk ? 0 : m_pre + 1;
        if (tk) m_cnt = (m_cnt == 1) ? m_chg : m_cnt - 1;
      end
      m_rst = ex;
      if (we_i) begin
        if (!addr_i[0]) begin
          nk = (k == 2) ? 3 : 2;
          step = (m_lock[k] == 3) ? 99 : m_lock[k];
          key = int'(wdata_i[15:0]);
          if (step < nk && key == keys[k][step]) m_lock[k] = (step + 1 == nk) ? 3 : step + 1;
          else if (key == keys[k][0]) m_lock[k] = 1;
          else m_lock[k] = 0;
        end else begin
          if (m_lock[k] == 3) begin
            if (k == 1) m_chg = (wdata_i == 0) ? 1 : (wdata_i > 32'hFFFF) ? 'hFFFF : d;
            if (k == 2) m_en = d & 1;
            if (k == 3) m_psc = (wdata_i[15:0] == 0) ? 1 : int'(wdata_i[15:0]);
          end
          m_lock[k] = 0;
        end
      end
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at cycle %0d", req, act, exp, cycles);
    end
  endtask

  // per-cycle comparison against the reference
  always @(negedge clk_i) begin
    #5;
    if (rst_ni && !done) begin
      check("R10 model rst", int'(wdt_rst_o), m_rst);
      check("R2 model rdata", int'(rdata_o), addr_i[0] ? 0 : m_lock[int'(addr_i) / 2]);
    end
  end

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 190000 && !done) begin
      done = 1;
      fails++; checks++;
      $display("FAIL watchdog: run did not finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic wr(int a, int d);
    @(negedge clk_i);
    addr_i = 3'(a); wdata_i = 32'(d); we_i = 1'b1;
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic rd(int a, int exp, string req);
    @(negedge clk_i);
    addr_i = 3'(a);
    #2 check(req, int'(rdata_o), exp);
  endtask

  task automatic unlock(int k);
    for (int s = 0; s < ((k == 2) ? 3 : 2); s++) wr(2 * k, keys[k][s]);
  endtask

  task automatic set_reg(int k, int d);
    unlock(k);
    wr(2 * k + 1, d);
  endtask

  task automatic measure(int exp, string req);
    int n = 0;
    do begin
      @(posedge clk_i); n++;
      @(negedge clk_i);
    end while (!wdt_rst_o && n < 70000);
    check(req, n, exp);
  endtask

  task automatic quiet(int n, string req);
    int hits = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      if (wdt_rst_o) hits++;
    end
    check(req, hits, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    check("R1 rst low", int'(wdt_rst_o), 0);
    for (int a = 0; a < 8; a += 2) rd(a, 0, "R1 guard idle");
    rd(3, 0, "R2 setting reads 0");

    wr(0, 'h5555); rd(0, 1, "R3 kick first key");
    wr(0, 'hAAAA); rd(0, 3, "R3 kick open");
    wr(2, 'h6666); rd(2, 1, "R3 change first key");
    wr(2, 'hBBBB); rd(2, 3, "R3 change open");
    wr(6, 'h5A5A); wr(6, 'hA5A5); rd(6, 3, "R3 prescale open");
    rd(7, 0, "R2 prescale reads 0");

    wr(2, 'h6666); wr(2, 'h1234); rd(2, 0, "R5 wrong key");
    wr(2, 'hBBBB); rd(2, 0, "R5 out of order");
    wr(2, 'h6666); wr(2, 'h6666); rd(2, 1, "R5 first key restarts");
    wr(4, 'hCCCC); rd(4, 0, "R5 three-key out of order");

    wr(4, 'h7777); rd(4, 1, "R4 step one");
    wr(4, 'hCCCC); rd(4, 2, "R4 step two");
    wr(4, 'hDDDD); rd(4, 3, "R4 open");
    wr(4, 'h7777); rd(4, 1, "R4 reopen restarts");

    wr(1, 1); rd(0, 0, "R6 kick write clears guard");
    wr(5, 1); rd(4, 0, "R6 enable write clears guard");
    quiet(60, "R6 locked enable ignored");

    set_reg(3, 4);
    set_reg(1, 5);
    wr(3, 9);
    set_reg(2, 1);
    set_reg(0, 1);
    measure(20, "R10 first timeout (R6 locked change ignored)");
    measure(20, "R10 periodic reload");

    set_reg(0, 1);
    for (int i = 0; i < 4; i++) begin
      quiet(8, "R8 keep-alive no reset");
      set_reg(0, 'h1234);
    end
    measure(20, "R8 kick reloads");

    set_reg(2, 0);
    quiet(100, "R7 disabled no reset");

    set_reg(3, 0);
    set_reg(1, 0);
    set_reg(2, 1);
    set_reg(0, 1);
    measure(1, "R9 zero clamps to one");
    set_reg(3, 'h10003);
    set_reg(1, 2);
    set_reg(0, 1);
    measure(6, "R9 prescale low bits");
    set_reg(3, 1);
    set_reg(1, 'h1FFFF);
    set_reg(0, 1);
    measure(65535, "R9 change clamps to max");

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule